// File: doc/BRIEF.md
# Abstract Register-Access Command Sequencer

This block sits in a debug controller between the debugger's register bus and a set of harts. A debugger writes a 32-bit command word. The block checks it against the halted state of the selected hart. If the command is legal, the block builds a short instruction sequence in a small abstract-program memory. That sequence moves one register (an integer register, a floating-point register or a CSR) to or from a shared data word. It then sets the hart's GO flag and raises busy. The hart fetches the sequence through a read port. When it has finished, it reports halted, and busy drops.

Failures are reported in a 3-bit sticky error field. A new command is refused while that field is nonzero, and software clears it by writing ones to it. A data word or program-buffer word can re-issue the last command when that word is accessed and the matching auto-execute bit is set. This is how block transfers are streamed.

Top module: `acmd_seq`

## Requirements
- R1: After reset, busy is 0, the error field is 0, all GO flags are 0, and the data words, program-buffer words and auto-execute masks all read 0.
- R2: A command whose bits 31:24 are nonzero is not a register access. It sets the error to 2 (not supported) and does not raise busy.
- R3: While the error field is nonzero, a command write changes neither busy nor the error. A command write while busy sets the error to 1 (busy).
- R4: A register-access command for a selected hart whose halted input is low sets the error to 4 (halt/resume). Nothing else changes.
- R5: The command fields are: register number in bits 15:0, write in bit 16, transfer in bit 17, postexec in bit 18, size in bits 22:20. When transfer is set, a size other than 2 or 3, or a register number of 0x1040 or above, sets the error to 2. Register numbers 0x1000–0x101F are integer registers, 0x1020–0x103F are floating-point registers, and numbers below 0x1000 are CSRs.
- R6: The generated words use these encodings. All loads and stores use base x0, the data-word address as offset, and funct3 equal to the size code. Integer loads use opcode 0x03 and integer stores 0x23; floating-point loads use 0x07 and floating-point stores 0x27. A GPR or FPR transfer is a single load (write) or store (read) of register number[4:0]. A CSR transfer is four words:
  - save s0 with csrrw x0,0x7B2,x8;
  - for a write: load s0, then csrrw x0,csr,x8;
  - for a read: csrrs x8,csr,x0, then store s0;
  - restore s0 with csrrs x8,0x7B2,x0.
- R7: The word after the transfer words (word 0 when transfer is clear) is a jal x0 to the program buffer when postexec is set, with offset PBUF_DIST − 4·index. Otherwise it is ebreak (0x00100073). All remaining words are 0.
- R8: A legal command sets busy and the GO flag of the selected hart. A pulse on hart_going clears the selected hart's GO flag. Busy clears only when a halt report names the selected hart while that hart's GO flag is clear.
- R9: While busy, reading a data word returns all ones and writing one leaves it unchanged; either access sets the error to 1 if it was 0. Program-buffer accesses while busy also read all ones and are ignored, but they set no error.
- R10: When not busy, a read or write of data word i (or program-buffer word i) re-issues the last command if bit i of the data auto-execute mask (or bit 16+i for the program buffer) is set. A write stores its value first.
- R11: Writing the status register clears each error bit where bit 2:0 of the written value is one. Status reads return the error in bits 2:0 and busy in bit 4.
- R12: An exception report from the hart sets the error to 3 only when the error is 0.
- R13: The register map is: data words at 0x04+i, status at 0x16, command at 0x17 (reads 0), auto-execute masks at 0x18, program-buffer words at 0x20+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reads have side effects) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hart_sel | input | SEL_W | Selected hart |
| hart_halted | input | NHARTS | Per-hart halted status |
| hart_going | input | 1 | Selected hart has picked up its GO flag |
| hart_halt_evt | input | 1 | A hart reports that it has halted |
| hart_halt_id | input | SEL_W | Hart named by hart_halt_evt |
| hart_exc | input | 1 | Hart took an exception in the sequence |
| fetch_idx | input | IDX_W | Abstract-program word index |
| fetch_word | output | 32 | Abstract-program word at fetch_idx |
| go_flags | output | NHARTS | Per-hart GO flags |
| busy | output | 1 | A command is in flight |
| err | output | 3 | Sticky error code |

## Verification
The assertions assume these input rules:
- Only one bus strobe is active per cycle.
- hart_sel does not change while busy.
- hart_going never arrives in the cycle a command launches.
- An exception report never coincides with a command write.

The stimulus keeps to these rules. Each bus access and each hart notification is a one-cycle pulse driven on the falling edge, and hart_sel changes only while idle. The halt-report and GO-clear handshakes always run in order: going first, then halted. The only exception is the deliberately early and wrong-hart halt reports, which test that busy holds.

// File: rtl/acmd_pkg.sv
`timescale 1ns/1ps
package acmd_pkg;
  localparam logic [2:0] ERR_NONE   = 3'd0;
  localparam logic [2:0] ERR_BUSY   = 3'd1;
  localparam logic [2:0] ERR_NOTSUP = 3'd2;
  localparam logic [2:0] ERR_EXC    = 3'd3;
  localparam logic [2:0] ERR_HALT   = 3'd4;

  localparam int A_DATA0 = 'h04;
  localparam int A_STAT  = 'h16;
  localparam int A_CMD   = 'h17;
  localparam int A_AUTO  = 'h18;
  localparam int A_PBUF0 = 'h20;
  localparam int AUTO_PBUF_LSB = 16;

  localparam logic [31:0] W_EBREAK    = 32'h0010_0073;
  localparam logic [11:0] CSR_SCRATCH = 12'h7B2;
  localparam logic [4:0]  R_ZERO      = 5'd0;
  localparam logic [4:0]  R_S0        = 5'd8;

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  // h holds offset bits 20:1 of a jal to x0
  function automatic logic [31:0] enc_jal(logic [19:0] h);
    return {h[19], h[9:0], h[10], h[18:11], 5'd0, 7'h6F};
  endfunction
endpackage

// File: rtl/acmd_gen.sv
`timescale 1ns/1ps
module acmd_gen
  import acmd_pkg::*;
#(
  parameter int          ABS_N     = 5,
  parameter logic [11:0] DATA_ADDR = 12'h380,
  parameter int          PBUF_DIST = 32
) (
  input  logic [31:0] cmd_i,
  output logic [31:0] words_o [ABS_N],
  output logic        bad_o
);
  localparam int IW = $clog2(ABS_N);

  logic [2:0]    size;
  logic [15:0]   regno;
  logic          wr, xfer, post;
  logic [4:0]    rnum;
  logic [6:0]    ld_op, st_op;
  logic [IW-1:0] n;
  logic [19:0]   offh;
  logic          unused_bits;

  assign unused_bits = ^{cmd_i[31:23], cmd_i[19]};

  always_comb begin
    size  = cmd_i[22:20];
    post  = cmd_i[18];
    xfer  = cmd_i[17];
    wr    = cmd_i[16];
    regno = cmd_i[15:0];
    rnum  = regno[4:0];
    ld_op = regno[5] ? 7'h07 : 7'h03;
    st_op = regno[5] ? 7'h27 : 7'h23;
    bad_o = 1'b0;
    n     = '0;
    for (int k = 0; k < ABS_N; k++) words_o[k] = '0;

    if (xfer) begin
      if (size != 3'd2 && size != 3'd3) begin
        bad_o = 1'b1;
      end else if (regno < 16'h1000) begin
        words_o[0] = enc_i(CSR_SCRATCH, R_S0, 3'd1, R_ZERO, 7'h73);
        if (wr) begin
          words_o[1] = enc_i(DATA_ADDR, R_ZERO, size, R_S0, 7'h03);
          words_o[2] = enc_i(regno[11:0], R_S0, 3'd1, R_ZERO, 7'h73);
        end else begin
          words_o[1] = enc_i(regno[11:0], R_ZERO, 3'd2, R_S0, 7'h73);
          words_o[2] = enc_s(DATA_ADDR, R_S0, R_ZERO, size, 7'h23);
        end
        words_o[3] = enc_i(CSR_SCRATCH, R_ZERO, 3'd2, R_S0, 7'h73);
        n = IW'(4);
      end else if (regno < 16'h1040) begin
        words_o[0] = wr ? enc_i(DATA_ADDR, R_ZERO, size, rnum, ld_op)
                        : enc_s(DATA_ADDR, rnum, R_ZERO, size, st_op);
        n = IW'(1);
      end else begin
        bad_o = 1'b1;
      end
    end

    offh = 20'(PBUF_DIST / 2) - 20'({n, 1'b0});
    if (!bad_o) words_o[n] = post ? enc_jal(offh) : W_EBREAK;
  end
endmodule

// File: rtl/acmd_goflags.sv
`timescale 1ns/1ps
module acmd_goflags #(
  parameter int NHARTS = 2,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_l,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              set_i,
  input  logic              clr_i,
  output logic [NHARTS-1:0] go_o
);
  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    logic hit;
    assign hit = (sel_i == SEL_W'(h));
    always_ff @(posedge clk or negedge rst_l) begin
      if (!rst_l)                     go_o[h] <= 1'b0;
      else if (hit && (set_i || clr_i)) go_o[h] <= set_i;
    end
  end
endmodule

// File: rtl/acmd_seq.sv
`timescale 1ns/1ps
module acmd_seq
  import acmd_pkg::*;
#(
  parameter int          NHARTS    = 2,
  parameter int          DATA_N    = 2,
  parameter int          PBUF_N    = 4,
  parameter int          ABS_N     = 5,
  parameter int          ADDR_W    = 7,
  parameter logic [11:0] DATA_ADDR = 12'h380,
  parameter int          PBUF_DIST = 32,
  parameter int          SEL_W     = (NHARTS > 1) ? $clog2(NHARTS) : 1,
  parameter int          IDX_W     = $clog2(ABS_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [SEL_W-1:0]  hart_sel,
  input  logic [NHARTS-1:0] hart_halted,
  input  logic              hart_going,
  input  logic              hart_halt_evt,
  input  logic [SEL_W-1:0]  hart_halt_id,
  input  logic              hart_exc,
  input  logic [IDX_W-1:0]  fetch_idx,
  output logic [31:0]       fetch_word,
  output logic [NHARTS-1:0] go_flags,
  output logic              busy,
  output logic [2:0]        err
);
  localparam int DIDX_W = (DATA_N > 1) ? $clog2(DATA_N) : 1;
  localparam int PIDX_W = (PBUF_N > 1) ? $clog2(PBUF_N) : 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  logic [31:0]       data_q [DATA_N];
  logic [31:0]       pbuf_q [PBUF_N];
  logic [31:0]       abs_q  [ABS_N];
  logic [31:0]       cmd_q;
  logic [DATA_N-1:0] auto_d_q;
  logic [PBUF_N-1:0] auto_p_q;
  logic              busy_q, busy_d;
  logic [2:0]        err_q, err_d, set_code;

  logic [ADDR_W-1:0] doff, poff;
  logic [DIDX_W-1:0] didx;
  logic [PIDX_W-1:0] pidx;
  logic is_data, is_pbuf, acc, cmd_wr, stat_wr, auto_wr, auto_hit;
  logic launch, set_v, data_we, pbuf_we;
  logic [31:0] cmd_eff;
  logic [31:0] gen_words [ABS_N];
  logic        gen_bad;

  acmd_gen #(.ABS_N(ABS_N), .DATA_ADDR(DATA_ADDR), .PBUF_DIST(PBUF_DIST)) u_gen (
    .cmd_i(cmd_eff), .words_o(gen_words), .bad_o(gen_bad));

  acmd_goflags #(.NHARTS(NHARTS), .SEL_W(SEL_W)) u_go (
    .clk(clk), .rst_l(rst_l), .sel_i(hart_sel), .set_i(launch),
    .clr_i(hart_going), .go_o(go_flags));

  // address decode and command outcome
  always_comb begin
    doff     = bus_addr - ADDR_W'(A_DATA0);
    poff     = bus_addr - ADDR_W'(A_PBUF0);
    is_data  = doff < ADDR_W'(DATA_N);
    is_pbuf  = poff < ADDR_W'(PBUF_N);
    didx     = doff[DIDX_W-1:0];
    pidx     = poff[PIDX_W-1:0];
    acc      = bus_rd | bus_wr;
    cmd_wr   = bus_wr && (bus_addr == ADDR_W'(A_CMD));
    stat_wr  = bus_wr && (bus_addr == ADDR_W'(A_STAT));
    auto_wr  = bus_wr && (bus_addr == ADDR_W'(A_AUTO));
    auto_hit = !busy_q && acc &&
               ((is_data && auto_d_q[didx]) || (is_pbuf && auto_p_q[pidx]));
    cmd_eff  = cmd_wr ? bus_wdata : cmd_q;
    data_we  = bus_wr && is_data && !busy_q;
    pbuf_we  = bus_wr && is_pbuf && !busy_q;

    launch   = 1'b0;
    set_v    = 1'b0;
    set_code = ERR_NONE;
    if ((cmd_wr || auto_hit) && err_q == ERR_NONE) begin
      set_v = 1'b1;
      if (busy_q)                        set_code = ERR_BUSY;
      else if (cmd_eff[31:24] != 8'd0)   set_code = ERR_NOTSUP;
      else if (!hart_halted[hart_sel])   set_code = ERR_HALT;
      else if (gen_bad)                  set_code = ERR_NOTSUP;
      else begin
        set_v  = 1'b0;
        launch = 1'b1;
      end
    end
    if (busy_q && is_data && acc) begin
      set_v    = 1'b1;
      set_code = ERR_BUSY;
    end
    if (hart_exc && !set_v) begin
      set_v    = 1'b1;
      set_code = ERR_EXC;
    end

    err_d = err_q & ~(stat_wr ? bus_wdata[2:0] : 3'b000);
    if (set_v && err_d == ERR_NONE) err_d = set_code;

    busy_d = busy_q;
    if (launch) busy_d = 1'b1;
    else if (hart_halt_evt && hart_halt_id == hart_sel && !go_flags[hart_sel]) busy_d = 1'b0;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      busy_q   <= 1'b0;
      err_q    <= ERR_NONE;
      cmd_q    <= '0;
      auto_d_q <= '0;
      auto_p_q <= '0;
      for (int k = 0; k < DATA_N; k++) data_q[k] <= '0;
      for (int k = 0; k < PBUF_N; k++) pbuf_q[k] <= '0;
      for (int k = 0; k < ABS_N; k++)  abs_q[k]  <= '0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
      if (cmd_wr)  cmd_q <= bus_wdata;
      if (auto_wr) begin
        auto_d_q <= bus_wdata[DATA_N-1:0];
        auto_p_q <= bus_wdata[AUTO_PBUF_LSB +: PBUF_N];
      end
      if (data_we) data_q[didx] <= bus_wdata;
      if (pbuf_we) pbuf_q[pidx] <= bus_wdata;
      if (launch) begin
        for (int k = 0; k < ABS_N; k++) abs_q[k] <= gen_words[k];
      end
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (is_data)      bus_rdata = busy_q ? '1 : data_q[didx];
    else if (is_pbuf) bus_rdata = busy_q ? '1 : pbuf_q[pidx];
    else if (bus_addr == ADDR_W'(A_STAT)) bus_rdata = {27'd0, busy_q, 1'b0, err_q};
    else if (bus_addr == ADDR_W'(A_AUTO))
      bus_rdata = 32'(auto_d_q) | (32'(auto_p_q) << AUTO_PBUF_LSB);
  end

  assign fetch_word = (int'(fetch_idx) < ABS_N) ? abs_q[fetch_idx] : '0;
  assign busy       = busy_q;
  assign err        = err_q;
endmodule

// File: rtl/acmd_seq_chk.sv
`timescale 1ns/1ps
module acmd_seq_chk
  import acmd_pkg::*;
#(
  parameter int NHARTS = 2,
  parameter int DATA_N = 2,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              hart_halt_evt,
  input logic              hart_exc,
  input logic [NHARTS-1:0] go_flags,
  input logic              busy,
  input logic [2:0]        err
);
  logic in_data;
  assign in_data = (bus_addr >= ADDR_W'(A_DATA0)) &&
                   (bus_addr <  ADDR_W'(A_DATA0 + DATA_N));

  // R12: error code stays within the defined set
  a_r12_err_legal: assert property (@(posedge clk) disable iff (!rst_n)
    err <= 3'd4);

  // R11: a nonzero error only changes through a status write
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 3'd0 && !(bus_wr && bus_addr == ADDR_W'(A_STAT))) |=> err == $past(err));

  // R8: busy rises together with a GO flag
  a_r8_busy_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> go_flags != '0);

  // R8: busy falls only after a halt report
  a_r8_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(hart_halt_evt));

  // R9: data words read as all ones while busy
  a_r9_busy_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_rd && in_data) |-> bus_rdata == 32'hFFFF_FFFF);

  // R2: a non-register-access command yields not supported
  a_r2_type_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && err == 3'd0 && !hart_exc && bus_wr && bus_addr == ADDR_W'(A_CMD) &&
     bus_wdata[31:24] != 8'd0) |=> (err == 3'd2 && !busy));

  logic unused_chk;
  assign unused_chk = ^bus_wdata[23:0];
endmodule

bind acmd_seq acmd_seq_chk #(.NHARTS(NHARTS), .DATA_N(DATA_N), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hart_halt_evt(hart_halt_evt),
  .hart_exc(hart_exc), .go_flags(go_flags), .busy(busy), .err(err));

// File: tb/acmd_seq_tb.sv
`timescale 1ns/1ps
module acmd_seq_tb;
  localparam logic [6:0] AD_DATA0 = 7'h04, AD_DATA1 = 7'h05, AD_STAT = 7'h16,
                         AD_CMD = 7'h17, AD_AUTO = 7'h18, AD_PB0 = 7'h20, AD_PB1 = 7'h21;
  localparam logic [11:0] DADDR = 12'h380;
  localparam int PDIST = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic hart_sel = 0, hart_going = 0, hart_halt_evt = 0, hart_halt_id = 0, hart_exc = 0;
  logic [1:0] hart_halted = 2'b11;
  logic [2:0] fetch_idx = '0;
  logic [31:0] fetch_word;
  logic [1:0] go_flags;
  logic busy;
  logic [2:0] err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hart_sel(hart_sel),
    .hart_halted(hart_halted), .hart_going(hart_going), .hart_halt_evt(hart_halt_evt),
    .hart_halt_id(hart_halt_id), .hart_exc(hart_exc), .fetch_idx(fetch_idx),
    .fetch_word(fetch_word), .go_flags(go_flags), .busy(busy), .err(err));

  typedef struct packed { logic [31:0] cmd; logic [2:0] err; } vec_t;
  localparam vec_t VECS [12] = '{
    '{32'h0022_1005, 3'd0},  // read x5, 32-bit
    '{32'h0037_1009, 3'd0},  // write x9, 64-bit, postexec
    '{32'h0022_1023, 3'd0},  // read f3, 32-bit
    '{32'h0037_103F, 3'd0},  // write f31, 64-bit, postexec
    '{32'h0022_0300, 3'd0},  // read CSR 0x300
    '{32'h0037_07B0, 3'd0},  // write CSR 0x7B0, postexec
    '{32'h0004_0000, 3'd0},  // no transfer, postexec
    '{32'h0000_0000, 3'd0},  // no transfer, ebreak
    '{32'h0040_0000, 3'd0},  // odd size but no transfer: legal
    '{32'h0012_1005, 3'd2},  // size 1 with transfer
    '{32'h0022_1040, 3'd2},  // register number out of range
    '{32'h0100_0000, 3'd2}   // other command type
  };

  function automatic logic [31:0] bi(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                     logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] bs(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                     logic [2:0] f3, logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction
  function automatic logic [31:0] bj(int off);
    logic [20:0] o;
    o = 21'(off);
    return {o[20], o[10:1], o[11], o[19:12], 5'd0, 7'h6F};
  endfunction

  function automatic logic [31:0] ew(logic [31:0] c, int k);
    logic [31:0] w [5];
    int n;
    logic [2:0] s;
    logic [15:0] r;
    for (int j = 0; j < 5; j++) w[j] = '0;
    s = c[22:20]; r = c[15:0]; n = 0;
    if (c[17]) begin
      if (r < 16'h1000) begin
        w[0] = bi(12'h7B2, 5'd8, 3'd1, 5'd0, 7'h73);
        if (c[16]) begin
          w[1] = bi(DADDR, 5'd0, s, 5'd8, 7'h03);
          w[2] = bi(r[11:0], 5'd8, 3'd1, 5'd0, 7'h73);
        end else begin
          w[1] = bi(r[11:0], 5'd0, 3'd2, 5'd8, 7'h73);
          w[2] = bs(DADDR, 5'd8, 5'd0, s, 7'h23);
        end
        w[3] = bi(12'h7B2, 5'd0, 3'd2, 5'd8, 7'h73);
        n = 4;
      end else begin
        if (c[16]) w[0] = bi(DADDR, 5'd0, s, r[4:0], (r < 16'h1020) ? 7'h03 : 7'h07);
        else       w[0] = bs(DADDR, r[4:0], 5'd0, s, (r < 16'h1020) ? 7'h23 : 7'h27);
        n = 1;
      end
    end
    w[n] = c[18] ? bj(PDIST - 4 * n) : 32'h0010_0073;
    return w[k];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic brd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic pulse_going();
    @(negedge clk); hart_going = 1;
    @(negedge clk); hart_going = 0;
  endtask

  task automatic pulse_halt(logic id);
    @(negedge clk); hart_halt_evt = 1; hart_halt_id = id;
    @(negedge clk); hart_halt_evt = 0;
  endtask

  task automatic finish_cmd(logic id);
    pulse_going();
    pulse_halt(id);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R8: watchdog expired, actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 go", 32'(go_flags), 0);
    brd(AD_DATA0, rd); chk("R1 data0", rd, 0);
    brd(AD_PB0, rd);   chk("R1 pbuf0", rd, 0);
    brd(AD_STAT, rd);  chk("R1 status", rd, 0);
    brd(AD_AUTO, rd);  chk("R1 auto", rd, 0);

    // vector table: R2 R5 R6 R7 R8
    foreach (VECS[i]) begin
      bwr(AD_STAT, 32'h7);
      bwr(AD_CMD, VECS[i].cmd);
      chk((VECS[i].cmd[31:24] != 0) ? "R2 err" : "R5 err", 32'(err), 32'(VECS[i].err));
      chk("R8 busy after issue", 32'(busy), 32'(VECS[i].err == 0));
      if (VECS[i].err == 0) begin
        chk("R8 go set", 32'(go_flags), 32'h1);
        for (int k = 0; k < 5; k++) begin
          fetch_idx = 3'(k);
          #1 chk("R6/R7 word", fetch_word, ew(VECS[i].cmd, k));
        end
        pulse_halt(0);
        chk("R8 busy held while GO set", 32'(busy), 1);
        pulse_going();
        chk("R8 go cleared", 32'(go_flags), 0);
        pulse_halt(0);
        chk("R8 busy cleared", 32'(busy), 0);
      end
    end

    // R4 not halted
    bwr(AD_STAT, 32'h7);
    hart_halted = 2'b10;
    bwr(AD_CMD, 32'h0022_1005);
    chk("R4 err", 32'(err), 4);
    chk("R4 busy", 32'(busy), 0);
    chk("R4 go", 32'(go_flags), 0);

    // R3 ignored while error set
    hart_halted = 2'b11;
    bwr(AD_CMD, 32'h0022_1005);
    chk("R3 err kept", 32'(err), 4);
    chk("R3 no busy", 32'(busy), 0);

    // R11 write one to clear
    bwr(AD_STAT, 32'h3);
    chk("R11 unrelated bits", 32'(err), 4);
    bwr(AD_STAT, 32'h4);
    brd(AD_STAT, rd); chk("R11 cleared", rd, 0);

    // R12 exception
    @(negedge clk); hart_exc = 1; @(negedge clk); hart_exc = 0;
    chk("R12 exc sets", 32'(err), 3);
    bwr(AD_STAT, 32'h7);
    hart_halted = 2'b10;
    bwr(AD_CMD, 32'h0022_1005);
    @(negedge clk); hart_exc = 1; @(negedge clk); hart_exc = 0;
    chk("R12 exc when set", 32'(err), 4);
    hart_halted = 2'b11;
    bwr(AD_STAT, 32'h7);

    // R9 busy accesses, R3 command while busy
    bwr(AD_DATA0, 32'h1234_5678);
    bwr(AD_CMD, 32'h0022_1005);
    chk("R9 launched", 32'(busy), 1);
    bwr(AD_CMD, 32'h0022_1005);
    chk("R3 busy err", 32'(err), 1);
    bwr(AD_STAT, 32'h7);
    chk("R11 busy kept", 32'(busy), 1);
    brd(AD_DATA0, rd);
    chk("R9 read ones", rd, 32'hFFFF_FFFF);
    chk("R9 read err", 32'(err), 1);
    bwr(AD_STAT, 32'h7);
    bwr(AD_DATA0, 32'h0000_DEAD);
    chk("R9 write err", 32'(err), 1);
    bwr(AD_STAT, 32'h7);
    brd(AD_PB0, rd);
    chk("R9 pbuf ones", rd, 32'hFFFF_FFFF);
    bwr(AD_PB0, 32'h55);
    chk("R9 pbuf no err", 32'(err), 0);
    finish_cmd(0);
    brd(AD_DATA0, rd); chk("R9 data kept", rd, 32'h1234_5678);
    brd(AD_PB0, rd);   chk("R9 pbuf kept", rd, 0);

    // R10 auto-execute, R13 map
    bwr(AD_AUTO, 32'h0002_0001);
    brd(AD_AUTO, rd); chk("R13 auto readback", rd, 32'h0002_0001);
    brd(AD_DATA1, rd);
    chk("R10 unmasked data", 32'(busy), 0);
    brd(AD_DATA0, rd);
    chk("R10 data auto", 32'(busy), 1);
    finish_cmd(0);
    bwr(AD_PB1, 32'h77);
    chk("R10 pbuf auto", 32'(busy), 1);
    finish_cmd(0);
    brd(AD_PB1, rd);
    chk("R10 pbuf stored", rd, 32'h77);
    chk("R10 pbuf read auto", 32'(busy), 1);
    finish_cmd(0);
    bwr(AD_PB0, 32'h1);
    chk("R10 unmasked pbuf", 32'(busy), 0);
    brd(AD_CMD, rd); chk("R13 command reads 0", rd, 0);

    // R8 second hart
    bwr(AD_AUTO, 32'h0);
    hart_sel = 1;
    bwr(AD_CMD, 32'h0022_1005);
    chk("R8 go hart1", 32'(go_flags), 32'h2);
    pulse_going();
    pulse_halt(0);
    chk("R8 wrong hart", 32'(busy), 1);
    pulse_halt(1);
    chk("R8 right hart", 32'(busy), 0);
    chk("R8 no err", 32'(err), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule